// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block turns a stream of stereo sample pairs into a three-wire serial audio output: a serial bit clock, a left/right word clock and one data line. It runs entirely in the link bit-clock domain. The serial clock is a registered divide-by-four of that clock, so every output is a plain flop output and no derived clock drives any logic. Each stereo frame is 64 serial clocks long, 32 per channel. A new pair of 20-bit samples is offered once per frame with a one-cycle strobe.

A two-bit selector picks one of four framings. These are a delayed-MSB framing with the word clock low for the left channel, left-justified, right-justified with all 20 bits, and right-justified with the top 16 bits. One shift register serves all four. Each framing only changes the slot position at which the word is loaded and how it is aligned. A control bit sends the arithmetic negative of every sample instead of the sample itself.

Top module: `serial_audio_tx`

## Requirements
- R1: The serial clock has a period of exactly 4 link clocks: high for 2 and low for 2.
- R2: The data line and the word clock change only in the link cycle in which the serial clock falls. A receiver can therefore latch data on the next rising edge.
- R3: Every word-clock half-period lasts exactly 32 serial clocks. With selector 00 the word clock is low during the left slot. With 01, 10 and 11 it is high during the left slot.
- R4: Selector 00: the first serial clock of a slot carries 0. The sample follows MSB first in slot positions 1 to 20, and positions 21 to 31 carry 0.
- R5: Selector 01: the sample is sent MSB first in slot positions 0 to 19, and positions 20 to 31 carry 0.
- R6: Selector 10: positions 0 to 11 carry 0, and the sample follows MSB first, so its LSB sits in position 31, the last serial clock before the word-clock edge.
- R7: Selector 11: only sample bits 19 down to 4 are sent, MSB first, in positions 16 to 31; positions 0 to 15 carry 0.
- R8: With the invert bit set, each channel sends the two's complement negative of its sample. The value 0x80000 is sent as 0x7FFFF instead.
- R9: A strobe captures both samples. A frame sends the pair that was held in the cycle before its left-slot load, and both channels of a frame come from the same pair. A strobe in the very cycle of that load goes to the following frame.
- R10: While reset is high, the serial clock and the data line are 0. The word clock sits at its right-slot level for the selected format.
- R11: Without a new strobe, each frame sends the last captured pair again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_left | input | 20 | Left sample, two's complement |
| smp_right | input | 20 | Right sample, two's complement |
| smp_valid | input | 1 | One-cycle strobe capturing both samples |
| fmt_sel | input | 2 | Framing: 00 delayed MSB, 01 left-justified, 10 right-justified 20 bit, 11 right-justified 16 bit |
| phase_inv | input | 1 | Send the negative of each sample |
| sclk_o | output | 1 | Serial bit clock, one quarter of clk |
| wclk_o | output | 1 | Left/right word clock |
| sdata_o | output | 1 | Serial data, changes on serial-clock falling edges |

## Verification
Two functions can fall in the same link cycle: capturing a new sample pair from the strobe, and loading the left slot's word into the shifter. The bench aims the strobe exactly at the load edge of each framing. That edge is 128 link cycles after the right slot begins, plus four cycles per slot position of the load point. The frame starting there must carry the previous pair in both channels, and the next frame must carry the new pair. The bench decodes the serial stream into 32-bit slot patterns and compares each one against a pattern built from the requirements.

// File: rtl/sat_pkg.sv
package sat_pkg;
  // Framing codes, as decoded from the two-bit selector
  typedef enum logic [1:0] {
    FMT_DELAYED  = 2'b00,
    FMT_LEFT     = 2'b01,
    FMT_RJ_FULL  = 2'b10,
    FMT_RJ_TRUNC = 2'b11
  } sat_fmt_e;
endpackage

// File: rtl/sat_clkgen.sv
// Serial clock divider and frame slot counter. DIV must be a power of two >= 2.
module sat_clkgen #(
  parameter int DIV   = 4,
  parameter int FRM_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  output logic             tick,
  output logic             sclk,
  output logic [FRM_W-1:0] slot_nxt
);
  localparam int DIV_W = $clog2(DIV);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_n;
  logic [FRM_W-1:0] slot_q;

  assign div_n    = div_q + 1'b1;
  assign tick     = (div_q == DIV_W'(DIV - 1));
  assign slot_nxt = slot_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      slot_q <= '1;   // first tick opens slot 0 of the left channel
      sclk   <= 1'b0;
    end else begin
      div_q <= div_n;
      sclk  <= div_n[DIV_W-1];
      if (tick) slot_q <= slot_nxt;
    end
  end
endmodule

// File: rtl/sat_sample_hold.sv
// Captures sample pairs, keeps a frame-coherent right sample, applies negation.
module sat_sample_hold #(
  parameter int SW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] smp_left,
  input  logic [SW-1:0] smp_right,
  input  logic          smp_valid,
  input  logic          take_left,
  input  logic          sel_right,
  input  logic          invert,
  output logic [SW-1:0] word
);
  localparam logic [SW-1:0] MOST_NEG = {1'b1, {(SW-1){1'b0}}};
  localparam logic [SW-1:0] MOST_POS = ~MOST_NEG;

  logic [SW-1:0] hold_l, hold_r, pair_r;
  logic [SW-1:0] raw;

  assign raw = sel_right ? pair_r : hold_l;

  always_comb begin
    if (!invert)              word = raw;
    else if (raw == MOST_NEG) word = MOST_POS;
    else                      word = (~raw) + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_l <= '0;
      hold_r <= '0;
      pair_r <= '0;
    end else begin
      if (smp_valid) begin
        hold_l <= smp_left;
        hold_r <= smp_right;
      end
      // right word of the frame is frozen when the left word is loaded
      if (take_left) pair_r <= hold_r;
    end
  end
endmodule

// File: rtl/sat_shifter.sv
// One MSB-first shifter; framing only changes the load alignment.
module sat_shifter
  import sat_pkg::*;
#(
  parameter int SW  = 20,
  parameter int TW  = 16,
  parameter int SHW = 24   // must exceed SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  sat_fmt_e      fmt,
  input  logic [SW-1:0] word,
  output logic          sdata
);
  logic [SHW-1:0] sh_q;
  logic [SHW-1:0] load_word;

  always_comb begin
    case (fmt)
      FMT_RJ_TRUNC: load_word = {word[SW-1 -: TW], {(SHW-TW){1'b0}}};
      default:      load_word = {word, {(SHW-SW){1'b0}}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else if (tick) begin
      sh_q <= load ? load_word : {sh_q[SHW-2:0], 1'b0};
    end
  end

  assign sdata = sh_q[SHW-1];
endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
  import sat_pkg::*;
#(
  parameter int SAMPLE_W  = 20,
  parameter int TRUNC_W   = 16,
  parameter int SLOT_W    = 24,
  parameter int HALF_BITS = 32,
  parameter int DIV       = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                smp_valid,
  input  logic [1:0]          fmt_sel,
  input  logic                phase_inv,
  output logic                sclk_o,
  output logic                wclk_o,
  output logic                sdata_o
);
  localparam int FRM_W          = $clog2(2 * HALF_BITS);
  localparam int POS_W          = FRM_W - 1;
  localparam int RJ_FULL_START  = HALF_BITS - SAMPLE_W;
  localparam int RJ_TRUNC_START = HALF_BITS - TRUNC_W;

  sat_fmt_e            fmt;
  logic                tick;
  logic [FRM_W-1:0]    slot_nxt;
  logic                half_nxt;
  logic [POS_W-1:0]    pos_nxt;
  logic [POS_W-1:0]    start_pos;
  logic                load;
  logic                take_left;
  logic [SAMPLE_W-1:0] word;
  logic                wclk_q;

  assign fmt      = sat_fmt_e'(fmt_sel);
  assign half_nxt = slot_nxt[FRM_W-1];
  assign pos_nxt  = slot_nxt[POS_W-1:0];

  always_comb begin
    case (fmt)
      FMT_DELAYED: start_pos = POS_W'(1);
      FMT_LEFT:    start_pos = '0;
      FMT_RJ_FULL: start_pos = POS_W'(RJ_FULL_START);
      default:     start_pos = POS_W'(RJ_TRUNC_START);
    endcase
  end

  assign load      = tick && (pos_nxt == start_pos);
  assign take_left = load && !half_nxt;

  sat_clkgen #(.DIV(DIV), .FRM_W(FRM_W)) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .sclk     (sclk_o),
    .slot_nxt (slot_nxt)
  );

  sat_sample_hold #(.SW(SAMPLE_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .smp_left  (smp_left),
    .smp_right (smp_right),
    .smp_valid (smp_valid),
    .take_left (take_left),
    .sel_right (half_nxt),
    .invert    (phase_inv),
    .word      (word)
  );

  sat_shifter #(.SW(SAMPLE_W), .TW(TRUNC_W), .SHW(SLOT_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .load  (load),
    .fmt   (fmt),
    .word  (word),
    .sdata (sdata_o)
  );

  // word clock: low on left for the delayed framing, high on left otherwise
  always_ff @(posedge clk) begin
    if (rst)       wclk_q <= (fmt == FMT_DELAYED);
    else if (tick) wclk_q <= (fmt == FMT_DELAYED) ? half_nxt : ~half_nxt;
  end

  assign wclk_o = wclk_q;
endmodule

// File: rtl/serial_audio_tx_chk.sv
module serial_audio_tx_chk #(
  parameter int SAMPLE_W  = 20,
  parameter int TRUNC_W   = 16,
  parameter int HALF_BITS = 32,
  parameter int DIV       = 4
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] fmt_sel,
  input logic       sclk_o,
  input logic       wclk_o,
  input logic       sdata_o
);
  localparam int POS_W = $clog2(HALF_BITS);
  localparam int CYC_W = $clog2(DIV) + 2;

  logic             sclk_d, wclk_d, sdata_d;
  logic             fall, rise, wedge;
  logic [POS_W-1:0] cnt_q, pos_c;
  logic             seen_q, rseen_q;
  logic [CYC_W-1:0] cyc_q;

  assign fall  = sclk_d && !sclk_o;
  assign rise  = sclk_o && !sclk_d;
  assign wedge = (wclk_o != wclk_d);

  always_comb begin
    if (wedge)     pos_c = '0;
    else if (fall) pos_c = cnt_q + 1'b1;
    else           pos_c = cnt_q;
  end

  always_ff @(posedge clk) begin
    sclk_d  <= sclk_o;
    wclk_d  <= wclk_o;
    sdata_d <= sdata_o;
    if (rst) begin
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      cyc_q   <= '0;
      rseen_q <= 1'b0;
    end else begin
      cnt_q <= pos_c;
      if (wedge) seen_q <= 1'b1;
      if (rise) begin
        cyc_q   <= CYC_W'(1);
        rseen_q <= 1'b1;
      end else if (cyc_q != '1) begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  p_sclk_period_r1: assert property (@(posedge clk) disable iff (rst)
    rseen_q && rise |-> cyc_q == CYC_W'(DIV));
  p_sclk_duty_r1: assert property (@(posedge clk) disable iff (rst)
    rseen_q && !rise |-> sclk_o == (cyc_q < CYC_W'(DIV / 2)));
  p_data_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    (sdata_o != sdata_d) |-> fall);
  p_wclk_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    wedge |-> fall);
  p_half_len_r3: assert property (@(posedge clk) disable iff (rst)
    seen_q && wedge |-> cnt_q == POS_W'(HALF_BITS - 1));
  p_pad_zero_r4: assert property (@(posedge clk) disable iff (rst)
    seen_q && fmt_sel == 2'b00 && (pos_c == '0 || int'(pos_c) > SAMPLE_W) |-> !sdata_o);
  p_pad_zero_r5: assert property (@(posedge clk) disable iff (rst)
    seen_q && fmt_sel == 2'b01 && int'(pos_c) >= SAMPLE_W |-> !sdata_o);
  p_pad_zero_r6: assert property (@(posedge clk) disable iff (rst)
    seen_q && fmt_sel == 2'b10 && int'(pos_c) < HALF_BITS - SAMPLE_W |-> !sdata_o);
  p_pad_zero_r7: assert property (@(posedge clk) disable iff (rst)
    seen_q && fmt_sel == 2'b11 && int'(pos_c) < HALF_BITS - TRUNC_W |-> !sdata_o);
  p_reset_state_r10: assert property (@(posedge clk)
    rst |=> (!sclk_o && !sdata_o && wclk_o == ($past(fmt_sel) == 2'b00)));
endmodule

bind serial_audio_tx serial_audio_tx_chk #(
  .SAMPLE_W  (SAMPLE_W),
  .TRUNC_W   (TRUNC_W),
  .HALF_BITS (HALF_BITS),
  .DIV       (DIV)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .fmt_sel (fmt_sel),
  .sclk_o  (sclk_o),
  .wclk_o  (wclk_o),
  .sdata_o (sdata_o)
);

// File: tb/serial_audio_tx_bench.sv
`timescale 1ns/1ps
module serial_audio_tx_bench;
  localparam int SW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [SW-1:0] smp_left = '0, smp_right = '0;
  logic          smp_valid = 1'b0;
  logic [1:0]    fmt_sel = 2'b00;
  logic          phase_inv = 1'b0;
  logic          sclk_o, wclk_o, sdata_o;

  int n_tests = 0;
  int n_fail  = 0;

  serial_audio_tx u_serial_audio_tx (
    .clk(clk), .rst(rst), .smp_left(smp_left), .smp_right(smp_right),
    .smp_valid(smp_valid), .fmt_sel(fmt_sel), .phase_inv(phase_inv),
    .sclk_o(sclk_o), .wclk_o(wclk_o), .sdata_o(sdata_o)
  );

  always #2.5 clk = ~clk;   // 200 MHz

  // scoreboard queues: one entry per frame
  logic [SW-1:0] exp_l_q[$];
  logic [SW-1:0] exp_r_q[$];
  string         tag_q[$];
  logic [SW-1:0] hold_l_m = '0, hold_r_m = '0;
  logic          mon_en = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] neg_sat(input logic [SW-1:0] s);
    if (s == 20'h80000) return 20'h7FFFF;
    return (~s) + 1'b1;
  endfunction

  // expected 32-bit slot pattern, first serial clock in bit 31
  function automatic logic [31:0] slot_pattern(input logic [1:0] f, input logic [SW-1:0] s);
    case (f)
      2'b00:   return {1'b0, s, 11'b0};      // R4
      2'b01:   return {s, 12'b0};            // R5
      2'b10:   return {12'b0, s};            // R6
      default: return {16'b0, s[19:4]};      // R7
    endcase
  endfunction

  function automatic string fmt_tag(input logic [1:0] f);
    case (f)
      2'b00:   return "R4";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic int start_pos(input logic [1:0] f);
    case (f)
      2'b00:   return 1;
      2'b01:   return 0;
      2'b10:   return 12;
      default: return 16;
    endcase
  endfunction

  // ---------------- monitor ----------------
  logic          p_sc, p_wc, p_sd;
  logic [31:0]   cap;
  int            pos, cyc;
  bit            seen_edge, rise_seen, have_cur, is_left;
  logic [SW-1:0] cur_l, cur_r;
  string         cur_tag;

  always @(negedge clk) begin
    if (!mon_en) begin
      pos = 0; cyc = 0; seen_edge = 0; rise_seen = 0; have_cur = 0;
    end else begin
      cyc++;
      // R2: data and word clock move only as the serial clock falls
      if (sdata_o !== p_sd || wclk_o !== p_wc)
        check(p_sc && !sclk_o, "R2 change off falling edge", {31'b0, sclk_o}, 32'h0);
      if (!p_sc && sclk_o) begin
        if (rise_seen) check(cyc == 4, "R1 serial clock period", cyc, 4);
        rise_seen = 1; cyc = 0;
        cap = {cap[30:0], sdata_o};
        pos++;
      end
      if (wclk_o !== p_wc) begin
        if (seen_edge) begin
          check(pos == 32, "R3 slot length", pos, 32);
          if (pos == 32) begin
            is_left = (p_wc == (fmt_sel != 2'b00));   // R3 polarity
            if (is_left && exp_l_q.size() > 0) begin
              cur_l = exp_l_q.pop_front();
              cur_r = exp_r_q.pop_front();
              cur_tag = tag_q.pop_front();
              have_cur = 1;
            end
            if (have_cur)
              check(cap == slot_pattern(fmt_sel, is_left ? cur_l : cur_r),
                    {fmt_tag(fmt_sel), " ", cur_tag, is_left ? " left" : " right"},
                    cap, slot_pattern(fmt_sel, is_left ? cur_l : cur_r));
          end
        end
        seen_edge = 1; pos = 0;
      end
    end
    p_sc = sclk_o; p_wc = wclk_o; p_sd = sdata_o;
  end

  // ---------------- driver ----------------
  task automatic wait_right_entry();
    logic rl, pw;
    bit   done;
    rl = (fmt_sel == 2'b00);
    pw = wclk_o;
    done = 0;
    while (!done) begin
      @(negedge clk);
      if (wclk_o == rl && pw != rl) done = 1;
      pw = wclk_o;
    end
  endtask

  task automatic push_exp(input bit inv, input string tag);
    exp_l_q.push_back(inv ? neg_sat(hold_l_m) : hold_l_m);
    exp_r_q.push_back(inv ? neg_sat(hold_r_m) : hold_r_m);
    tag_q.push_back(tag);
  endtask

  // applies a pair late in the right slot; it belongs to the next frame
  task automatic drive(input bit new_pair, input logic [SW-1:0] l, input logic [SW-1:0] r,
                       input bit inv, input string tag);
    wait_right_entry();
    repeat (80) @(posedge clk);
    @(negedge clk);
    phase_inv = inv;
    if (new_pair) begin
      smp_left = l; smp_right = r; smp_valid = 1'b1;
      hold_l_m = l; hold_r_m = r;
    end
    push_exp(inv, tag);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  // R9: strobe lands in the same cycle as the left-slot load
  task automatic collide(input logic [SW-1:0] l, input logic [SW-1:0] r);
    wait_right_entry();
    repeat (127 + 4 * start_pos(fmt_sel)) @(posedge clk);
    @(negedge clk);
    push_exp(phase_inv, "R9 collision keeps old pair");
    smp_left = l; smp_right = r; smp_valid = 1'b1;
    hold_l_m = l; hold_r_m = r;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  initial begin
    for (int f = 0; f < 4; f++) begin
      @(negedge clk);
      mon_en = 1'b0; rst = 1'b1;
      fmt_sel = 2'(f); phase_inv = 1'b0; smp_valid = 1'b0;
      hold_l_m = '0; hold_r_m = '0;
      exp_l_q.delete(); exp_r_q.delete(); tag_q.delete();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10 reset state
      check(sclk_o == 1'b0, "R10 reset sclk", {31'b0, sclk_o}, 32'h0);
      check(sdata_o == 1'b0, "R10 reset data", {31'b0, sdata_o}, 32'h0);
      check(wclk_o == (fmt_sel == 2'b00), "R10 reset word clock",
            {31'b0, wclk_o}, {31'b0, (fmt_sel == 2'b00)});
      rst = 1'b0; mon_en = 1'b1;

      drive(1, 20'hA5A5A, 20'h3C3C3, 0, "pattern A");
      drive(1, 20'h00001, 20'hFFFFF, 0, "pattern B");
      drive(1, 20'h80000, 20'h00000, 1, "R8 saturate");
      drive(1, 20'h12345, 20'h7FFFF, 1, "R8 negate");
      drive(0, '0, '0, 1, "R11 repeat");
      drive(1, 20'h5F00F, 20'hABCDE, 0, "pattern C");
      collide(20'h6789A, 20'h0F0F0);
      drive(0, '0, '0, 0, "R9 pair after collision");
      drive(1, 20'h7FFFF, 20'h80000, 0, "extremes");
      wait_right_entry();
      wait_right_entry();
      check(exp_l_q.size() == 0, "R9 one frame per captured pair", exp_l_q.size(), 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule